// File: doc/BRIEF.md
# Per-Character Blink Attribute Controller

This block keeps a one-bit blink attribute for each of eight character positions of a small dot-matrix display. It turns those bits into per-position blank enables, so that marked characters alternate between shown and hidden. A host writes the attributes through a strobed interface. The write counts only while the attribute-select input is high. The low three address bits pick the position, and data bit 0 gives the new value.

A free-running divider of the system clock produces the blink waveform. One full cycle lasts 28,672 clocks: the first half is the visible phase and the second half is the blanked phase. A global enable, taken from a control register outside this block, gates every blank output. The display pipeline combines each blank enable with its own character output. The current attribute vector can also be read back.

Top module: `blink_attr_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every attribute bit reads 0 and every blank output is 0.
- R2: A write (`wr_stb` = 1 and `attr_sel` = 1 at a rising clock edge) loads `wr_data[0]` into the attribute of position `wr_addr[2:0]`. The new value shows on `attr_rd` after that edge, and the other seven positions keep their values.
- R3: During a write, `wr_addr[4:3]` and `wr_data[7:1]` have no effect: only position `wr_addr[2:0]` changes, and it takes the value of bit 0.
- R4: A strobe with `attr_sel` = 0 leaves every attribute bit unchanged.
- R5: `blank[i]` is 1 exactly when `glob_en` = 1, attribute `i` = 1 and the divider is in its blanked phase.
- R6: The blink waveform repeats every 28,672 clock cycles.
- R7: The visible and blanked phases each last 14,336 clocks. The first 14,336 clocks after reset are visible, which means that the first blanked clock follows rising edge 14,336 after reset.
- R8: With `glob_en` = 0, all blank outputs are 0. Dropping the enable changes neither the attributes nor the divider's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| attr_sel | input | 1 | Selects the attribute storage for a write |
| wr_stb | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 5 | Write address; only bits 2:0 are used |
| wr_data | input | 8 | Write data; only bit 0 is used |
| glob_en | input | 1 | Global blink enable from the control register |
| attr_rd | output | 8 | Current attribute vector |
| blank | output | 8 | Per-position blank enable |
| blank_phase | output | 1 | 1 during the blanked half of the blink cycle |

## Verification
The bench builds the block with its default parameters, so the half period is 14,336 and there are eight positions. With these values the exact 28,672-clock period and both phase lengths are measured edge by edge from reset. The bench also sweeps set and clear across all eight positions, using every value of the ignored address bits and an ignored data pattern. Blank outputs are compared with several attribute patterns in both phases, and with the global enable high and low.

// File: rtl/blink_attr_pkg.sv
package blink_attr_pkg;
    parameter int unsigned NUM_POS     = 8;
    parameter int unsigned HALF_PERIOD = 14336;
    localparam int unsigned POS_W      = $clog2(NUM_POS);
    localparam int unsigned CNT_W      = $clog2(HALF_PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } div_state_t;

    typedef struct packed {
        logic [NUM_POS-1:0] bits;
    } attr_state_t;
endpackage

// File: rtl/blink_attr_store.sv
module blink_attr_store
    import blink_attr_pkg::*;
#(
    parameter int unsigned N_POS = NUM_POS,
    parameter int unsigned IDX_W = $clog2(N_POS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    output logic [N_POS-1:0] attr_q
);
    logic [N_POS-1:0] attr_d;
    logic [N_POS-1:0] bits_q;

    always_comb begin
        attr_d = bits_q;
        if (wr_en) begin
            attr_d[wr_idx] = wr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= attr_d;
    end

    assign attr_q = bits_q;

    // R2: the addressed bit takes the written value
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bits_q[$past(wr_idx)] == $past(wr_bit));

    // R4: without a write, the storage holds its value
    p_no_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bits_q));
endmodule

// File: rtl/blink_div.sv
module blink_div
    import blink_attr_pkg::*;
#(
    parameter int unsigned HALF  = HALF_PERIOD,
    parameter int unsigned CW    = $clog2(HALF)
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_q
);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_q = st_q.phase;

    // R6: the counter wraps to zero after its last value
    p_cnt_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST) |=> (st_q.cnt == '0));

    // R7: the phase flips exactly at the wrap
    p_phase_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST) |=> (st_q.phase != $past(st_q.phase)));

    // R7: the phase holds between wraps
    p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != LAST) |=> $stable(st_q.phase));

    // R6: the counter never runs past its last value
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/blink_gate.sv
module blink_gate
    import blink_attr_pkg::*;
#(
    parameter int unsigned N_POS = NUM_POS
) (
    input  logic             en,
    input  logic             phase,
    input  logic [N_POS-1:0] attr,
    output logic [N_POS-1:0] blank
);
    for (genvar g = 0; g < N_POS; g++) begin : g_pos
        assign blank[g] = en & phase & attr[g];
    end
endmodule

// File: rtl/blink_attr_ctrl.sv
module blink_attr_ctrl
    import blink_attr_pkg::*;
#(
    parameter int unsigned N_POS  = NUM_POS,
    parameter int unsigned HALF   = HALF_PERIOD,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attr_sel,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              glob_en,
    output logic [N_POS-1:0]  attr_rd,
    output logic [N_POS-1:0]  blank,
    output logic              blank_phase
);
    localparam int unsigned IDX_W = $clog2(N_POS);

    logic             wr_go;
    logic [IDX_W-1:0] wr_idx;
    logic             phase;

    assign wr_go  = wr_stb & attr_sel;
    assign wr_idx = wr_addr[IDX_W-1:0];

    blink_attr_store #(.N_POS(N_POS), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_go),
        .wr_idx (wr_idx),
        .wr_bit (wr_data[0]),
        .attr_q (attr_rd)
    );

    blink_div #(.HALF(HALF), .CW($clog2(HALF))) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase)
    );

    blink_gate #(.N_POS(N_POS)) u_gate (
        .en    (glob_en),
        .phase (phase),
        .attr  (attr_rd),
        .blank (blank)
    );

    assign blank_phase = phase;

    // R5: a position blanks only when its stored attribute is set
    p_blank_needs_attr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blank & ~attr_rd) == '0);

    // R8: a low global enable leaves every blank output clear
    p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (blank == '0));

    // R7: no blanking during the visible phase
    p_visible_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_phase |-> (blank == '0));
endmodule

// File: tb/blink_attr_ctrl_tb_top.sv
module blink_attr_ctrl_tb_top;
    localparam int HALF = 14336;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       attr_sel = 1'b0;
    logic       wr_stb = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       glob_en = 1'b0;
    logic [7:0] attr_rd;
    logic [7:0] blank;
    logic       blank_phase;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = '0;

    always #5 clk = ~clk;

    blink_attr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .attr_sel(attr_sel), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .glob_en(glob_en),
        .attr_rd(attr_rd), .blank(blank), .blank_phase(blank_phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write cycle, driven at a falling edge, committed on the next rising edge
    task automatic wr(input logic sel, input logic [4:0] a, input logic [7:0] d);
        attr_sel = sel; wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        attr_sel = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
        if (sel) model[a[2:0]] = d[0];
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        glob_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk("R1 attr in reset", attr_rd, 0);
        chk("R1 blank in reset", blank, 0);
        rst_n = 1'b1;
        // R7: write attr 0 on rising edge 1, then count edges to first blank
        wr(1'b1, 5'd0, 8'h01);
        chk("R1 blank after reset", blank, 0);
        chk("R2 first write", attr_rd, 8'h01);
        cnt = 1;
        while (!blank[0] && cnt < 40000) begin @(negedge clk); cnt++; end
        chk("R7 visible phase from reset", cnt, HALF);
        cnt = 0;
        while (blank[0] && cnt < 40000) begin @(negedge clk); cnt++; end
        chk("R7 blanked phase length", cnt, HALF);
        begin
            int low = 0;
            while (!blank[0] && low < 40000) begin @(negedge clk); low++; end
            chk("R7 visible phase length", low, HALF);
            chk("R6 full period", cnt + low, 2 * HALF);
        end
        // now at the start of a blanked phase: HALF-1 clocks remain
        // R2/R3: sweep each position with all ignored address bits, set then clear
        for (int p = 0; p < 8; p++) begin
            for (int hi = 0; hi < 4; hi++) begin
                wr(1'b1, {hi[1:0], p[2:0]}, 8'hA5 | 8'h01);
                chk("R2 set position", attr_rd, model);
                wr(1'b1, {hi[1:0], p[2:0]}, 8'hFE);
                chk("R3 clear with ignored bits", attr_rd, model);
            end
            wr(1'b1, {2'b11, p[2:0]}, 8'h81);
        end
        chk("R3 all set via high addr", attr_rd, 8'hFF);
        // R4: strobes without select do nothing
        for (int p = 0; p < 8; p++) wr(1'b0, p[4:0], 8'h00);
        chk("R4 unselected strobes", attr_rd, 8'hFF);
        // R5: patterns in blanked phase
        for (int k = 0; k < 8; k++) begin
            logic [7:0] pat;
            pat = 8'h5A ^ (8'h1 << k) ^ 8'(k * 37);
            for (int p = 0; p < 8; p++) wr(1'b1, p[4:0], {7'h3F, pat[p]});
            chk("R2 pattern stored", attr_rd, pat);
            chk("R5 blank in blanked phase", blank, blank_phase ? pat : 8'h00);
        end
        chk("R5 still in blanked phase", blank_phase, 1);
        // R8: drop enable mid-phase
        glob_en = 1'b0;
        #1;
        chk("R8 blank off with enable low", blank, 0);
        chk("R8 attrs kept", attr_rd, model);
        chk("R8 phase kept", blank_phase, 1);
        repeat (10) @(negedge clk);
        glob_en = 1'b1;
        #1;
        chk("R8 blank returns", blank, model);
        // R5: wait into visible phase, blank must clear
        cnt = 0;
        while (blank_phase && cnt < 40000) begin @(negedge clk); cnt++; end
        chk("R5 blank clear in visible phase", blank, 0);
        chk("R5 attrs unchanged across phase", attr_rd, model);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule